// File: doc/BRIEF.md
# Time base counter with periodic interrupts

The block divides a 256 Hz step strobe, itself a division of the 32.768 kHz crystal clock, into eight tap frequencies from 128 Hz down to 1 Hz. Software reads the taps as two 4-bit nibbles over a small register bus. Three periodic interrupt sources fire on the falling edges of the 32 Hz, 8 Hz and 2 Hz taps. Each source has its own enable bit and its own factor flag. A flag clears when software reads it.

One control bit starts the count. Writing that bit to 0 stops the count and clears it. The step strobe `tick_i` is a one-cycle pulse in the `clk_i` domain. It is generated elsewhere at twice the fastest tap rate.

Top module: `timebase_ctr`

## Requirements
- R1: After reset, both tap nibbles, the control register and the flag register read 0, and `irq_o` is 0.
- R2: Address 0 reads count bits 3..0, so D0 is 128 Hz, D1 is 64 Hz, D2 is 32 Hz and D3 is 16 Hz. Address 1 reads count bits 7..4, so D0 is 8 Hz, D1 is 4 Hz, D2 is 2 Hz and D3 is 1 Hz.
- R3: While the run bit is 1, each clock edge with `tick_i` high advances the 8-bit count by one. The count wraps from 255 to 0.
- R4: A write to address 2 with D3=0 sets the count to 0 at that edge and stops it. A write with D3=1 sets the run bit and leaves the count unchanged.
- R5: While the run bit is 0, `tick_i` leaves the count unchanged.
- R6: The control register is at address 2, with D3 as the run bit, D2 as the 2 Hz enable, D1 as the 8 Hz enable and D0 as the 32 Hz enable. It reads back as written.
- R7: Address 3 reads the factor flags, with D2 for 2 Hz, D1 for 8 Hz, D0 for 32 Hz, and D3 always 0. A clock edge with `rd_i` high and address 3 clears every flag that is not being set at that edge.
- R8: A flag sets at the edge where counting takes its tap (count bit 2, 4 or 6) from 1 to 0. Clearing the count by a stop does not set a flag.
- R9: A flag sets whatever its enable holds. `irq_o` is high exactly when some flag is 1 and its enable is also 1.
- R10: When a flag set and a flag read fall on the same edge, the flag ends up 1.
- R11: Writes to addresses 0, 1 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 256 Hz step strobe, one cycle wide |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; a read of address 3 clears the flags |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 4 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Interrupt request: enabled flags ORed together |

## Verification
The assertions check, on every cycle, the counter step, the clear on stop and the hold while stopped. They also check that every tap falling edge lands in its flag, that a read without a coincident set empties a flag, and that writes to read-only addresses leave the control state alone. Only the bench's scenarios can show that the nibble packing and the bit positions seen on the bus match the frequencies. The same holds for the mask gating of `irq_o` with the enables both on and off, for the count wrap, and for the same-edge set-and-read race, which is driven at a chosen count value.

// File: rtl/tbc_pkg.sv
`timescale 1ns/1ps
package tbc_pkg;
  localparam int DATA_W = 4;
  localparam int N_IRQ  = 3;
  localparam int RUN_BIT = 3;
  localparam logic [1:0] A_TAP_LO = 2'd0;
  localparam logic [1:0] A_TAP_HI = 2'd1;
  localparam logic [1:0] A_CTRL   = 2'd2;
  localparam logic [1:0] A_FLAG   = 2'd3;
  // count bit watched by each interrupt source: 32 Hz, 8 Hz, 2 Hz
  localparam int IRQ_TAP [N_IRQ] = '{2, 4, 6};
endpackage

// File: rtl/tbc_counter.sv
`timescale 1ns/1ps
module tbc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o = run_i & tick_i & ~clr_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !clr_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(run_i && tick_i)) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/tbc_irq.sv
`timescale 1ns/1ps
module tbc_irq
  import tbc_pkg::*;
#(
  parameter int TAP_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_W-1:0] cnt_i,
  input  logic             step_i,
  input  logic [N_IRQ-1:0] en_i,
  input  logic             rd_clr_i,
  output logic [N_IRQ-1:0] flag_o,
  output logic             irq_o
);
  logic [N_IRQ-1:0] set;
  logic [N_IRQ-1:0] flag_q;

  for (genvar k = 0; k < N_IRQ; k++) begin : g_src
    // a tap falls on the step that carries out of all bits up to it
    assign set[k] = step_i & (&cnt_i[IRQ_TAP[k]:0]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= set[k] | (flag_q[k] & ~rd_clr_i);
    end

    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[k] |=> flag_q[k]); // R10
    AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr_i && !set[k]) |=> !flag_q[k]); // R7
  end

  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_i);
endmodule

// File: rtl/timebase_ctr.sv
`timescale 1ns/1ps
module timebase_ctr
  import tbc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;
  localparam int TAP_W = IRQ_TAP[N_IRQ-1] + 1;

  logic             run_q;
  logic [N_IRQ-1:0] en_q;
  logic [CNT_W-1:0] cnt;
  logic             step;
  logic [N_IRQ-1:0] flag;
  logic             ctrl_wr, clr, rd_clr;

  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign clr     = ctrl_wr && !wdata_i[RUN_BIT];
  assign rd_clr  = rd_i && (addr_i == A_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      en_q  <= '0;
    end else if (ctrl_wr) begin
      run_q <= wdata_i[RUN_BIT];
      en_q  <= wdata_i[N_IRQ-1:0];
    end
  end

  tbc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .clr_i  (clr),
    .tick_i (tick_i),
    .cnt_o  (cnt),
    .step_o (step)
  );

  tbc_irq #(.TAP_W(TAP_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt[TAP_W-1:0]),
    .step_i   (step),
    .en_i     (en_q),
    .rd_clr_i (rd_clr),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (addr_i)
      A_TAP_LO: rdata_o = cnt[DATA_W-1:0];
      A_TAP_HI: rdata_o = cnt[CNT_W-1:DATA_W];
      A_CTRL:   rdata_o = DATA_W'({run_q, en_q});
      default:  rdata_o = DATA_W'(flag);
    endcase
  end

  AST_RO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != A_CTRL) |=> $stable({run_q, en_q})); // R11
  AST_STOPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> cnt == '0); // R4
endmodule

// File: tb/sim_timebase_ctr.sv
`timescale 1ns/1ps
module sim_timebase_ctr;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic irq;

  int vectors = 0;
  int misses = 0;

  // reference state
  int m_cnt = 0;
  int m_run = 0;
  int m_en = 0;
  int m_flag = 0;

  always #10 clk = ~clk;

  timebase_ctr u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_cnt % 16;                // R2
      1: return m_cnt / 16;                // R2
      2: return m_run * 8 + m_en;          // R6
      default: return m_flag;              // R7
    endcase
  endfunction

  function automatic string req_of(input int a);
    case (a)
      0, 1: return "R2";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    int e;
    e = exp_rd(int'(addr));
    vectors++;
    if (int'(rdata) != e) begin
      misses++;
      $display("FAIL %s addr=%0d rdata=%0d expected=%0d", req_of(int'(addr)), addr, rdata, e);
    end
    vectors++;
    if (irq !== ((m_flag & m_en) != 0)) begin
      misses++;
      $display("FAIL R9 irq=%0b expected=%0b", irq, (m_flag & m_en) != 0);
    end
  endtask

  task automatic model_edge();
    int nc;
    int fl;
    bit clr;
    clr = wr && addr == 2 && !wdata[3];
    nc = m_cnt;
    fl = 0;
    if (clr) nc = 0;
    else if (m_run != 0 && tick) begin
      nc = (m_cnt + 1) % 256;
      if (m_cnt[2] && !nc[2]) fl |= 1;    // R8 32 Hz
      if (m_cnt[4] && !nc[4]) fl |= 2;    // R8 8 Hz
      if (m_cnt[6] && !nc[6]) fl |= 4;    // R8 2 Hz
    end
    if (rd && addr == 3) m_flag = 0;
    m_flag |= fl;                          // R10 set wins
    if (wr && addr == 2) begin
      m_run = wdata[3];
      m_en = wdata[2:0];
    end
    m_cnt = nc;
  endtask

  task automatic step(input int a, input bit w, input bit r, input int d, input bit t);
    @(negedge clk);
    addr = 2'(a); wr = w; rd = r; wdata = 4'(d); tick = t;
    #1 compare();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R1 reset contents
    for (int a = 0; a < 4; a++) step(a, 0, 0, 0, 0);
    // R6 enables on, still stopped; R5 ticks ignored while stopped
    step(2, 1, 0, 4'b0111, 0);
    for (int i = 0; i < 8; i++) step(i % 4, 0, 0, 0, 1);
    // R3 R8 R9 run past a wrap, reading the flags now and then
    step(2, 1, 0, 4'b1111, 0);
    for (int i = 0; i < 640; i++) begin
      if (i % 9 == 0) step(3, 0, 1, 0, i % 2);
      else step(i % 4, 0, 0, 0, i % 2);
    end
    // R4 run bit written to 1 again leaves count; then stop clears it
    step(2, 1, 0, 4'b1111, 1);
    step(0, 0, 0, 0, 1);
    step(2, 1, 0, 4'b0101, 1);
    for (int i = 0; i < 6; i++) step(i % 2, 0, 0, 0, 1);   // R5
    // R11 writes to read-only addresses
    step(0, 1, 0, 4'b1111, 0);
    step(1, 1, 0, 4'b1010, 0);
    step(3, 1, 0, 4'b1111, 0);
    for (int a = 0; a < 4; a++) step(a, 0, 0, 0, 0);
    // R10 flag set and read on the same edge at count 7
    step(3, 0, 1, 0, 0);
    step(2, 1, 0, 4'b1001, 0);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 1);
    step(3, 0, 1, 0, 1);
    step(3, 0, 0, 0, 0);
    step(3, 0, 1, 0, 0);
    step(3, 0, 0, 0, 0);
    // R9 all masks off: flags set, irq stays low
    step(2, 1, 0, 4'b1000, 0);
    for (int i = 0; i < 300; i++) step(i % 4, 0, 0, 0, 1);
    step(2, 1, 0, 4'b1100, 0);
    step(3, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule